// File: doc/BRIEF.md
# Macroblock Residual Block Sequencer

This block walks the residual sub-blocks of one video macroblock in decoding order and tells a downstream inverse-transform datapath what to do at each step: which block index is next, which colour component it belongs to and which inverse transform applies. The datapath does the arithmetic and owns the coefficient storage. This block only issues steps and accepts a ready handshake for each one.

A macroblock has a 16x16 luma area made of sixteen 4x4 blocks and two 8x8 chroma areas, Cb and Cr, each made of four 4x4 blocks. A macroblock coded in intra-16x16 mode carries an extra luma DC block that gathers the DC terms of all sixteen luma blocks. Every macroblock carries one 2x2 chroma DC block per chroma component. Each DC block is followed by a scatter phase. In that phase the sequencer issues one write address per DC element, pointing at the upper-left coefficient of the 4x4 block that receives it.

A start strobe, sampled together with the intra-16x16 flag, launches one macroblock. A one-cycle done pulse marks the acceptance of the last chroma block.

Top module: `mb_resid_seq`

## Requirements
- R1: After reset, and until a start is accepted, blk_valid_o, dcw_valid_o and done_o are all low.
- R2: With the intra flag high at start, the steps are: block -1, sixteen luma DC writes, blocks 0 to 15, block 16, four Cb DC writes, block 17, four Cr DC writes, then blocks 18 to 25. The index is a 6-bit two's complement value, so -1 is 6'h3F.
- R3: With the intra flag low at start, the order of R2 applies without block -1 and without its sixteen writes.
- R4: blk_xform_o is 1 (4x4 Hadamard) for block -1, 2 (2x2 Hadamard) for blocks 16 and 17, and 0 (4x4 integer inverse) for every other block.
- R5: blk_comp_o is 0 (luma) for blocks -1 to 15 and for the luma DC writes. It is 1 (Cb) for blocks 16 and 18 to 21 and for the Cb DC writes. It is 2 (Cr) for blocks 17 and 22 to 25 and for the Cr DC writes.
- R6: The k-th luma DC write (dcw_elem_o = k, k from 0 to 15) carries address k*16. The coefficient address is block*16 plus position, and position 0 is the upper-left coefficient.
- R7: The j-th Cb DC write (j from 0 to 3) carries address (18+j)*16. The j-th Cr DC write carries (22+j)*16.
- R8: A step is accepted in a cycle where its valid and rdy_i are both high, and the next step appears in the following cycle. While rdy_i is low, every output holds.
- R9: blk_valid_o and dcw_valid_o are never high together.
- R10: done_o is high for exactly one cycle, in the cycle after block 25 is accepted. From that cycle on, both valids stay low until the next start.
- R11: A start strobe while a macroblock is in progress is ignored. The intra flag is used only in the cycle of an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch one macroblock, honoured only when idle |
| intra16_i | input | 1 | Macroblock mode, sampled with an accepted start |
| rdy_i | input | 1 | Datapath accepts the current step |
| blk_valid_o | output | 1 | A transform step is offered |
| blk_idx_o | output | IDX_W (6) | Signed block index of the step |
| blk_comp_o | output | 2 | Component: 0 luma, 1 Cb, 2 Cr |
| blk_xform_o | output | 2 | Transform: 0 integer 4x4, 1 Hadamard 4x4, 2 Hadamard 2x2 |
| dcw_valid_o | output | 1 | A DC scatter write is offered |
| dcw_elem_o | output | log2(LUMA_N) (4) | Element number within the DC result |
| dcw_addr_o | output | ADDR_W (9) | Coefficient address of the target upper-left position |
| done_o | output | 1 | One-cycle end-of-macroblock pulse |

## Verification
The hold properties assume the datapath never withdraws a step on its own side: a valid output that meets a low rdy_i must be offered again unchanged. The bench's ready source only stalls and releases, so that assumption always holds. The bench pulses start only for a single cycle. Some of those pulses fall in the middle of a macroblock, with the intra flag set opposite to the running mode, to exercise R11. rdy_i is driven with several patterns (always high, alternating, pseudo-random and long stalls) so that acceptance also falls on the phase boundaries between DC, scatter and AC steps.

// File: rtl/mbseq_pkg.sv
package mbseq_pkg;
   typedef enum logic [1:0] {
      XF_INT4 = 2'd0,
      XF_HAD4 = 2'd1,
      XF_HAD2 = 2'd2
   } xform_e;

   typedef enum logic [1:0] {
      CP_LUMA = 2'd0,
      CP_CB   = 2'd1,
      CP_CR   = 2'd2
   } comp_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LDC,
      PH_LSCAT,
      PH_LAC,
      PH_CDC,
      PH_CSCAT,
      PH_CAC
   } phase_e;
endpackage

// File: rtl/mbseq_ctrl.sv
module mbseq_ctrl
   import mbseq_pkg::*;
#(
   parameter int LUMA_N = 16,
   parameter int CHR_N  = 4,
   parameter int CNT_W  = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             intra16_i,
   input  logic             rdy_i,
   output phase_e           phase_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             csel_o,
   output logic             done_o
);
   localparam logic [CNT_W-1:0] LUMA_LAST = CNT_W'(LUMA_N - 1);
   localparam logic [CNT_W-1:0] CSC_LAST  = CNT_W'(CHR_N - 1);
   localparam logic [CNT_W-1:0] CAC_LAST  = CNT_W'(2 * CHR_N - 1);

   phase_e           ph_q, ph_n;
   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic             cs_q, cs_n;
   logic             fin_n, done_q;
   logic             adv;

   assign adv = rdy_i && (ph_q != PH_IDLE);

   always_comb begin
      ph_n  = ph_q;
      cnt_n = cnt_q;
      cs_n  = cs_q;
      fin_n = 1'b0;
      unique case (ph_q)
         PH_IDLE: if (start_i) begin
            ph_n  = intra16_i ? PH_LDC : PH_LAC;
            cnt_n = '0;
            cs_n  = 1'b0;
         end
         PH_LDC: if (adv) begin
            ph_n  = PH_LSCAT;
            cnt_n = '0;
         end
         PH_LSCAT: if (adv) begin
            if (cnt_q == LUMA_LAST) begin
               ph_n  = PH_LAC;
               cnt_n = '0;
            end else begin
               cnt_n = cnt_q + 1'b1;
            end
         end
         PH_LAC: if (adv) begin
            if (cnt_q == LUMA_LAST) begin
               ph_n  = PH_CDC;
               cnt_n = '0;
               cs_n  = 1'b0;
            end else begin
               cnt_n = cnt_q + 1'b1;
            end
         end
         PH_CDC: if (adv) begin
            ph_n  = PH_CSCAT;
            cnt_n = '0;
         end
         PH_CSCAT: if (adv) begin
            cnt_n = '0;
            if (cnt_q != CSC_LAST) begin
               cnt_n = cnt_q + 1'b1;
            end else if (!cs_q) begin
               ph_n = PH_CDC;
               cs_n = 1'b1;
            end else begin
               ph_n = PH_CAC;
            end
         end
         PH_CAC: if (adv) begin
            if (cnt_q == CAC_LAST) begin
               ph_n  = PH_IDLE;
               cnt_n = '0;
               fin_n = 1'b1;
            end else begin
               cnt_n = cnt_q + 1'b1;
            end
         end
         default: ph_n = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         cs_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         ph_q   <= ph_n;
         cnt_q  <= cnt_n;
         cs_q   <= cs_n;
         done_q <= fin_n;
      end
   end

   assign phase_o = ph_q;
   assign cnt_o   = cnt_q;
   assign csel_o  = cs_q;
   assign done_o  = done_q;
endmodule

// File: rtl/mbseq_decode.sv
module mbseq_decode
   import mbseq_pkg::*;
#(
   parameter int LUMA_N = 16,
   parameter int CHR_N  = 4,
   parameter int CNT_W  = 4,
   parameter int IDX_W  = 6,
   parameter int BLK_W  = 5
) (
   input  phase_e                  phase_i,
   input  logic [CNT_W-1:0]        cnt_i,
   input  logic                    csel_i,
   output logic                    blk_valid_o,
   output logic                    dcw_valid_o,
   output logic signed [IDX_W-1:0] idx_o,
   output comp_e                   comp_o,
   output xform_e                  xform_o,
   output logic [BLK_W-1:0]        tgt_o
);
   localparam int CAC_BASE = LUMA_N + 2;

   comp_e chroma_c;
   assign chroma_c = csel_i ? CP_CR : CP_CB;

   always_comb begin
      blk_valid_o = 1'b0;
      dcw_valid_o = 1'b0;
      idx_o       = '0;
      comp_o      = CP_LUMA;
      xform_o     = XF_INT4;
      tgt_o       = '0;
      unique case (phase_i)
         PH_LDC: begin
            blk_valid_o = 1'b1;
            idx_o       = '1;
            xform_o     = XF_HAD4;
         end
         PH_LSCAT: begin
            dcw_valid_o = 1'b1;
            tgt_o       = BLK_W'(cnt_i);
         end
         PH_LAC: begin
            blk_valid_o = 1'b1;
            idx_o       = IDX_W'(cnt_i);
         end
         PH_CDC: begin
            blk_valid_o = 1'b1;
            idx_o       = IDX_W'(LUMA_N) + IDX_W'(csel_i);
            comp_o      = chroma_c;
            xform_o     = XF_HAD2;
         end
         PH_CSCAT: begin
            dcw_valid_o = 1'b1;
            comp_o      = chroma_c;
            tgt_o       = BLK_W'(CAC_BASE) + (csel_i ? BLK_W'(CHR_N) : '0) + BLK_W'(cnt_i);
         end
         PH_CAC: begin
            blk_valid_o = 1'b1;
            idx_o       = IDX_W'(CAC_BASE) + IDX_W'(cnt_i);
            comp_o      = (cnt_i < CNT_W'(CHR_N)) ? CP_CB : CP_CR;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/mbseq_addr.sv
module mbseq_addr #(
   parameter int BLK_W  = 5,
   parameter int COEF_N = 16,
   parameter int ADDR_W = 9
) (
   input  logic              valid_i,
   input  logic [BLK_W-1:0]  tgt_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int POS_W = $clog2(COEF_N);

   logic [ADDR_W-1:0] raw;

   generate
      if ((COEF_N & (COEF_N - 1)) == 0) begin : g_shift
         assign raw = ADDR_W'({tgt_i, {POS_W{1'b0}}});
      end else begin : g_mult
         assign raw = ADDR_W'(32'(tgt_i) * COEF_N);
      end
   endgenerate

   assign addr_o = valid_i ? raw : '0;
endmodule

// File: rtl/mb_resid_seq.sv
module mb_resid_seq
   import mbseq_pkg::*;
#(
   parameter int IDX_W  = 6,
   parameter int LUMA_N = 16,
   parameter int CHR_N  = 4,
   parameter int COEF_N = 16,
   localparam int NBLK   = LUMA_N + 2 + 2 * CHR_N,
   localparam int BLK_W  = $clog2(NBLK),
   localparam int CNT_W  = $clog2(LUMA_N),
   localparam int ADDR_W = $clog2(NBLK * COEF_N)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              intra16_i,
   input  logic              rdy_i,
   output logic              blk_valid_o,
   output logic [IDX_W-1:0]  blk_idx_o,
   output logic [1:0]        blk_comp_o,
   output logic [1:0]        blk_xform_o,
   output logic              dcw_valid_o,
   output logic [CNT_W-1:0]  dcw_elem_o,
   output logic [ADDR_W-1:0] dcw_addr_o,
   output logic              done_o
);
   generate
      if (IDX_W < $clog2(NBLK) + 1) begin : g_bad_idx
         $error("IDX_W too narrow for a signed block index");
      end
      if (2 * CHR_N > LUMA_N || LUMA_N < 2) begin : g_bad_cnt
         $error("chroma block count must fit the luma counter");
      end
      if (COEF_N < 2) begin : g_bad_coef
         $error("COEF_N must be at least 2");
      end
   endgenerate

   phase_e                  phase;
   logic [CNT_W-1:0]        cnt;
   logic                    csel;
   logic signed [IDX_W-1:0] idx;
   comp_e                   comp;
   xform_e                  xform;
   logic [BLK_W-1:0]        tgt;
   logic                    dv;

   mbseq_ctrl #(.LUMA_N(LUMA_N), .CHR_N(CHR_N), .CNT_W(CNT_W)) ctrl_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start_i),
      .intra16_i (intra16_i),
      .rdy_i     (rdy_i),
      .phase_o   (phase),
      .cnt_o     (cnt),
      .csel_o    (csel),
      .done_o    (done_o)
   );

   mbseq_decode #(.LUMA_N(LUMA_N), .CHR_N(CHR_N), .CNT_W(CNT_W),
                  .IDX_W(IDX_W), .BLK_W(BLK_W)) dec_i (
      .phase_i     (phase),
      .cnt_i       (cnt),
      .csel_i      (csel),
      .blk_valid_o (blk_valid_o),
      .dcw_valid_o (dv),
      .idx_o       (idx),
      .comp_o      (comp),
      .xform_o     (xform),
      .tgt_o       (tgt)
   );

   mbseq_addr #(.BLK_W(BLK_W), .COEF_N(COEF_N), .ADDR_W(ADDR_W)) addr_i (
      .valid_i (dv),
      .tgt_i   (tgt),
      .addr_o  (dcw_addr_o)
   );

   assign dcw_valid_o = dv;
   assign dcw_elem_o  = dv ? cnt : '0;
   assign blk_idx_o   = idx;
   assign blk_comp_o  = comp;
   assign blk_xform_o = xform;
endmodule

// File: rtl/mbseq_chk.sv
module mbseq_chk #(
   parameter int IDX_W  = 6,
   parameter int LUMA_N = 16,
   parameter int CHR_N  = 4,
   parameter int COEF_N = 16,
   parameter int CNT_W  = 4,
   parameter int ADDR_W = 9
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              rdy_i,
   input logic              blk_valid_o,
   input logic [IDX_W-1:0]  blk_idx_o,
   input logic [1:0]        blk_comp_o,
   input logic [1:0]        blk_xform_o,
   input logic              dcw_valid_o,
   input logic [CNT_W-1:0]  dcw_elem_o,
   input logic [ADDR_W-1:0] dcw_addr_o,
   input logic              done_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LUMA_N + 1 + 2 * CHR_N);
   localparam logic [IDX_W-1:0] CDC0     = IDX_W'(LUMA_N);
   localparam logic [IDX_W-1:0] CDC1     = IDX_W'(LUMA_N + 1);
   localparam int               POS_W    = $clog2(COEF_N);

   // R9
   valid_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({blk_valid_o, dcw_valid_o}));

   // R8
   blk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      blk_valid_o && !rdy_i |=> blk_valid_o && $stable(blk_idx_o)
                                && $stable(blk_comp_o) && $stable(blk_xform_o));

   // R8
   dcw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dcw_valid_o && !rdy_i |=> dcw_valid_o && $stable(dcw_addr_o)
                                && $stable(dcw_elem_o) && $stable(blk_comp_o));

   // R10
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R10
   done_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      blk_valid_o && rdy_i && blk_idx_o == LAST_IDX |=> done_o);

   // R10
   done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !blk_valid_o && !dcw_valid_o);

   // R4
   had2_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      blk_valid_o && blk_xform_o == 2'd2 |-> blk_idx_o == CDC0 || blk_idx_o == CDC1);

   // R4
   had4_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      blk_valid_o && blk_xform_o == 2'd1 |-> blk_idx_o == '1);

   // R6
   dcw_corner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dcw_valid_o |-> dcw_addr_o[POS_W-1:0] == '0);

   // R7
   dcw_chroma_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dcw_valid_o && blk_comp_o != 2'd0 |-> 32'(dcw_addr_o) >= (LUMA_N + 2) * COEF_N);
endmodule

bind mb_resid_seq mbseq_chk #(
   .IDX_W(IDX_W), .LUMA_N(LUMA_N), .CHR_N(CHR_N), .COEF_N(COEF_N),
   .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .rdy_i       (rdy_i),
   .blk_valid_o (blk_valid_o),
   .blk_idx_o   (blk_idx_o),
   .blk_comp_o  (blk_comp_o),
   .blk_xform_o (blk_xform_o),
   .dcw_valid_o (dcw_valid_o),
   .dcw_elem_o  (dcw_elem_o),
   .dcw_addr_o  (dcw_addr_o),
   .done_o      (done_o)
);

// File: tb/mb_resid_seq_tb.sv
`timescale 1ns/100ps
module mb_resid_seq_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       intra = 1'b0;
   logic       rdy = 1'b0;
   logic       blk_v, dcw_v, done;
   logic [5:0] idx;
   logic [1:0] comp, xf;
   logic [3:0] elem;
   logic [8:0] addr;

   always #2.5 clk = ~clk;

   mb_resid_seq dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .intra16_i(intra), .rdy_i(rdy),
      .blk_valid_o(blk_v), .blk_idx_o(idx), .blk_comp_o(comp), .blk_xform_o(xf),
      .dcw_valid_o(dcw_v), .dcw_elem_o(elem), .dcw_addr_o(addr), .done_o(done)
   );

   int    n_chk = 0, n_fail = 0;
   int    q_kind[$], q_idx[$], q_comp[$], q_xf[$], q_elem[$], q_addr[$];
   bit    exp_done = 0, run_intra = 0, mon_en = 0, was_stall = 0;
   int    rdy_mode = 0;
   string ovr = "";

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", (ovr != "") ? ovr : tag, what, act, exp);
      end
   endtask

   task automatic push(int k, int i, int c, int x, int e, int a);
      q_kind.push_back(k); q_idx.push_back(i); q_comp.push_back(c);
      q_xf.push_back(x); q_elem.push_back(e); q_addr.push_back(a);
   endtask

   // expected step list, built from R2..R7
   task automatic load_mb(bit in16);
      run_intra = in16;
      if (in16) begin
         push(0, -1, 0, 1, 0, 0);
         for (int k = 0; k < 16; k++) push(1, 0, 0, 0, k, k * 16);
      end
      for (int b = 0; b < 16; b++) push(0, b, 0, 0, 0, 0);
      for (int c = 0; c < 2; c++) begin
         push(0, 16 + c, 1 + c, 2, 0, 0);
         for (int j = 0; j < 4; j++) push(1, 0, 1 + c, 0, j, (18 + 4 * c + j) * 16);
      end
      for (int b = 18; b < 26; b++) push(0, b, (b < 22) ? 1 : 2, 0, 0, 0);
   endtask

   always @(negedge clk) if (mon_en) begin
      string ordt;
      bit    nd;
      ordt = run_intra ? "R2" : "R3";
      chk(!(blk_v && dcw_v), "R9", "both valids", {blk_v, dcw_v}, 0);
      if (q_kind.size() == 0) begin
         chk(!blk_v && !dcw_v, exp_done ? "R10" : "R1", "idle valids", {blk_v, dcw_v}, 0);
         chk(done == exp_done, "R10", "done", done, exp_done);
      end else begin
         string t;
         t = was_stall ? "R8" : ordt;
         chk(done == 0, "R10", "early done", done, 0);
         if (q_kind[0] == 0) begin
            chk(blk_v && !dcw_v, t, "block step valid", {blk_v, dcw_v}, 2);
            chk($signed(idx) == q_idx[0], t, "block index", $signed(idx), q_idx[0]);
            chk(xf == q_xf[0], was_stall ? "R8" : "R4", "transform", xf, q_xf[0]);
            chk(comp == q_comp[0], was_stall ? "R8" : "R5", "component", comp, q_comp[0]);
         end else begin
            t = was_stall ? "R8" : ((q_comp[0] == 0) ? "R6" : "R7");
            chk(dcw_v && !blk_v, t, "write step valid", {blk_v, dcw_v}, 1);
            chk(elem == q_elem[0], t, "dc element", elem, q_elem[0]);
            chk(addr == q_addr[0], t, "dc address", addr, q_addr[0]);
            chk(comp == q_comp[0], was_stall ? "R8" : "R5", "write component", comp, q_comp[0]);
         end
      end
      nd = 0;
      was_stall = 0;
      if (q_kind.size() == 0) begin
         if (start) load_mb(intra);
      end else if (rdy) begin
         void'(q_kind.pop_front()); void'(q_idx.pop_front()); void'(q_comp.pop_front());
         void'(q_xf.pop_front()); void'(q_elem.pop_front()); void'(q_addr.pop_front());
         if (q_kind.size() == 0) nd = 1;
      end else begin
         was_stall = 1;
      end
      exp_done = nd;
   end

   int lfsr = 32'h1d3;
   always @(posedge clk) begin
      #1;
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h80200003 : 0);
      case (rdy_mode)
         0: rdy <= 1'b1;
         1: rdy <= ~rdy;
         2: rdy <= (lfsr % 3) != 0;
         default: rdy <= (lfsr % 8) == 0;
      endcase
   end

   // R11: optional mid-run start with the opposite mode flag
   task automatic run_mb(bit in16, int mode, bit inject);
      rdy_mode = mode;
      @(posedge clk); #1;
      intra = in16; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0; intra = ~in16;
      if (inject) begin
         repeat (9) @(posedge clk);
         #1; ovr = "R11"; start = 1'b1;
         @(posedge clk); #1; start = 1'b0;
         repeat (30) @(posedge clk);
         ovr = "";
      end
      do @(posedge clk); while (q_kind.size() != 0);
      repeat (3) @(posedge clk);
   endtask

   initial begin
      #(5.0 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(!blk_v && !dcw_v, "R1", "reset valids", {blk_v, dcw_v}, 0);
      chk(done == 0, "R1", "reset done", done, 0);
      @(posedge clk); #1; rst_n = 1'b1;
      mon_en = 1;
      repeat (4) @(posedge clk);
      run_mb(1'b1, 0, 1'b0);   // R2
      run_mb(1'b0, 0, 1'b0);   // R3
      run_mb(1'b1, 1, 1'b0);   // R8 alternating ready
      run_mb(1'b0, 2, 1'b0);
      run_mb(1'b1, 3, 1'b1);   // R11 with long stalls
      run_mb(1'b0, 2, 1'b1);   // R11 mode flag ignored
      run_mb(1'b1, 2, 1'b0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule